// File: doc/BRIEF.md
# Fine-Grained Mesh Logic Cell

This block is one cell of a mesh of identical cells. Each cell is wired only to its four compass neighbours, with no separate routing fabric. The cell takes one bit from each neighbour and drives one bit toward each neighbour. Each of the four outgoing bits is computed by a private 3-input lookup table. Every lookup-table input is picked by its own 8-way selector. The eight choices are the four neighbour bits and the cell's own four registered results.

Routing is therefore done by the logic itself. A lookup table set to the identity of one selected input passes a signal across the cell. Two such tables can carry signals in opposite directions at the same time.

Each output can be taken straight from its lookup table or from a register clocked by the cell. The register form delays a value by one cycle, which aligns micro-pipelined data across cells. Feeding the registers back through the selectors lets a cell hold state, for example a toggle or a counter bit.

Configuration is 72 bits. It is shifted in serially into a shadow store. It takes effect only on a commit strobe, so the cell keeps running its old function while a new one is loaded.

Top module: `mesh_logic_cell`

## Requirements
- R1: A synchronous active-high `rst` clears all four output registers to 0. The loaded configuration survives reset and governs behaviour as soon as `rst` falls.
- R2: While `cfg_en` is high, each rising clock edge shifts `cfg_bit` into the shadow store, most significant bit first. After 72 such edges the first bit shifted in sits at bit 71. While `cfg_en` is low, `cfg_bit` has no effect.
- R3: The shadow store affects the outputs only after `cfg_commit` has been high on a clock edge. Until then the cell keeps its previous function.
- R4: Each lookup table forms a 3-bit address whose bit 2 is selector 2's output and whose bit 0 is selector 0's output. The table drives truth-table bit `address`.
- R5: Selector code values 0, 1, 2 and 3 choose the north, south, west and east inputs (`nb_in` bits 0 to 3). Codes 4 to 7 choose the registered results of outputs 0 to 3.
- R6: When an output's mode bit is 1, the output shows its register, which loads the table result on each clock edge. When the mode bit is 0, the output shows the table result with no clock delay.
- R7: The four outputs are independent. One cell can pass south to north and north to south while computing other functions on its west and east outputs.
- R8: Output k (0 north, 1 south, 2 west, 3 east) is configured by word bits [18k+17:18k]. Within that slice, bit 17 is the mode, bits 16:14 are selector 2, bits 13:11 are selector 1, bits 10:8 are selector 0, and bits 7:0 are the truth table.
- R9: Each output register loads its table result on every edge outside reset, whatever the mode. A combinational output can therefore be read back one cycle later through codes 4 to 7.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Cell clock |
| rst | input | 1 | Synchronous active-high reset of the output registers |
| nb_in | input | 4 | Neighbour inputs: bit 0 north, 1 south, 2 west, 3 east |
| cfg_en | input | 1 | Shift enable for the serial configuration input |
| cfg_bit | input | 1 | Serial configuration data, most significant bit first |
| cfg_commit | input | 1 | Copies the shadow store into the active configuration |
| nb_out | output | 4 | Neighbour outputs: bit 0 north, 1 south, 2 west, 3 east |

## Verification
A wrong selector code or truth-table bit shows up on the combinational outputs in the same cycle as the input vector that addresses it. This is why one configuration is swept across many neighbour patterns, including asymmetric functions that expose a swapped address order. A corrupted shadow shift stays hidden until the commit, then appears at once as a wrong function. Register and feedback faults appear one or two edges after an input change, or as a broken toggle sequence, so these are sampled edge by edge.

// File: rtl/cell_pkg.sv
package cell_pkg;

    localparam int SIDES   = 4;
    localparam int LUT_K   = 3;
    localparam int SRC_N   = 2 * SIDES;
    localparam int SEL_W   = $clog2(SRC_N);
    localparam int TT_W    = 1 << LUT_K;
    localparam int SLICE_W = 1 + LUT_K * SEL_W + TT_W;
    localparam int CFG_W   = SIDES * SLICE_W;

    typedef enum logic [1:0] {
        SIDE_N = 2'd0,
        SIDE_S = 2'd1,
        SIDE_W = 2'd2,
        SIDE_E = 2'd3
    } side_e;

    typedef logic [SEL_W-1:0] sel_code_t;

    typedef struct packed {
        logic                        registered;
        sel_code_t [LUT_K-1:0]       sel;
        logic [TT_W-1:0]             truth;
    } slice_cfg_t;

    function automatic logic lut_read(input logic [TT_W-1:0] truth,
                                      input logic [LUT_K-1:0] addr);
        return truth[addr];
    endfunction

endpackage

// File: rtl/cell_cfg_store.sv
module cell_cfg_store
    import cell_pkg::*;
(
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    cfg_en,
    input  logic                    cfg_bit,
    input  logic                    cfg_commit,
    output slice_cfg_t [SIDES-1:0]  active
);

    logic [CFG_W-1:0] shadow_q;
    logic [CFG_W-1:0] active_q;

    always_ff @(posedge clk) begin
        if (cfg_en) begin
            shadow_q <= {shadow_q[CFG_W-2:0], cfg_bit};
        end
        if (cfg_commit) begin
            active_q <= shadow_q;
        end
    end

    assign active = active_q;

    AST_SHIFT_ENTRY: assert property (@(posedge clk) disable iff (rst)
        cfg_en |=> shadow_q[0] == $past(cfg_bit)) else $error("shift entry"); // R2
    AST_SHADOW_HOLD: assert property (@(posedge clk) disable iff (rst)
        !cfg_en |=> $stable(shadow_q)) else $error("shadow moved"); // R2
    AST_ACTIVE_HOLD: assert property (@(posedge clk) disable iff (rst)
        !cfg_commit |=> $stable(active_q)) else $error("active moved"); // R3

endmodule

// File: rtl/cell_out_slice.sv
module cell_out_slice
    import cell_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  slice_cfg_t        cfg,
    input  logic [SRC_N-1:0]  src,
    output logic              q,
    output logic              out
);

    logic [LUT_K-1:0] addr;
    logic             lut_val;

    generate
        for (genvar j = 0; j < LUT_K; j++) begin : g_sel
            assign addr[j] = src[cfg.sel[j]];
        end
    endgenerate

    assign lut_val = lut_read(cfg.truth, addr);

    always_ff @(posedge clk) begin
        if (rst) begin
            q <= 1'b0;
        end else begin
            q <= lut_val;
        end
    end

    assign out = cfg.registered ? q : lut_val;

    AST_REG_CLEAR: assert property (@(posedge clk)
        rst |=> !q) else $error("reg not cleared"); // R1
    AST_REG_DELAY: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && cfg.registered && $stable(cfg)) |-> out == $past(lut_val))
        else $error("registered path"); // R6
    AST_REG_FOLLOW: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |-> q == $past(lut_val)) else $error("reg load"); // R9

endmodule

// File: rtl/mesh_logic_cell.sv
module mesh_logic_cell
    import cell_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic [3:0]  nb_in,
    input  logic        cfg_en,
    input  logic        cfg_bit,
    input  logic        cfg_commit,
    output logic [3:0]  nb_out
);

    slice_cfg_t [SIDES-1:0] active;
    logic [SIDES-1:0]       q_bus;
    logic [SRC_N-1:0]       src_bus;

    assign src_bus = {q_bus, nb_in};

    cell_cfg_store u_store (
        .clk        (clk),
        .rst        (rst),
        .cfg_en     (cfg_en),
        .cfg_bit    (cfg_bit),
        .cfg_commit (cfg_commit),
        .active     (active)
    );

    generate
        for (genvar k = 0; k < SIDES; k++) begin : g_side
            cell_out_slice u_slice (
                .clk (clk),
                .rst (rst),
                .cfg (active[k]),
                .src (src_bus),
                .q   (q_bus[k]),
                .out (nb_out[k])
            );
        end
    endgenerate

    AST_RESET_OUT: assert property (@(posedge clk)
        (rst && cfg_en == 1'b0 && !cfg_commit) |=> (q_bus == '0)) else $error("reset q"); // R1

endmodule

// File: tb/mesh_logic_cell_bench.sv
`timescale 1ns/1ps
module mesh_logic_cell_bench;
    import cell_pkg::*;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [3:0] nb_in = '0;
    logic       cfg_en = 1'b0;
    logic       cfg_bit = 1'b0;
    logic       cfg_commit = 1'b0;
    logic [3:0] nb_out;

    int n_checks = 0;
    int n_fail = 0;
    bit done = 0;

    always #10 clk = ~clk;

    mesh_logic_cell u_mesh_logic_cell (
        .clk(clk), .rst(rst), .nb_in(nb_in), .cfg_en(cfg_en),
        .cfg_bit(cfg_bit), .cfg_commit(cfg_commit), .nb_out(nb_out)
    );

    // vector: {nb_in, expected nb_out} for configuration A
    localparam logic [7:0] VEC [9] = '{
        {4'b0000, 4'h0}, {4'b0001, 4'hE}, {4'b0010, 4'h5},
        {4'b0100, 4'h0}, {4'b1000, 4'h4}, {4'b0101, 4'h6},
        {4'b1011, 4'hF}, {4'b1111, 4'h7}, {4'b0011, 4'hB}
    };

    function automatic logic [SLICE_W-1:0] sl(input logic m, input int s2,
        input int s1, input int s0, input logic [7:0] tt);
        return {m, 3'(s2), 3'(s1), 3'(s0), tt};
    endfunction

    // R8 layout: output 3 in the top slice
    // A: N<-S, S<-N, W<-E^N^S, E<-N&~W (all combinational)
    logic [CFG_W-1:0] cfg_a, cfg_b, cfg_c;
    initial begin
        cfg_a = {sl(0,0,3,2,8'h50), sl(0,1,0,3,8'h96), sl(0,0,0,0,8'hAA), sl(0,0,0,1,8'hAA)};
        cfg_b = {sl(1,0,0,7,8'h55), sl(1,0,0,2,8'hAA), sl(1,0,0,1,8'hAA), sl(1,0,0,0,8'hAA)};
        cfg_c = {sl(0,0,0,0,8'hFF), sl(0,0,0,0,8'h00), sl(1,0,0,4,8'hAA), sl(0,0,0,0,8'hAA)};
    end

    task automatic check(input string req, input logic [3:0] got, input logic [3:0] exp);
        n_checks++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got %h expected %h", req, got, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic load(input logic [CFG_W-1:0] w);
        for (int i = CFG_W - 1; i >= 0; i--) begin
            cfg_en = 1'b1;
            cfg_bit = w[i];
            tick();
        end
        cfg_en = 1'b0;
    endtask

    task automatic commit();
        cfg_commit = 1'b1;
        tick();
        cfg_commit = 1'b0;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
            $finish;
        end
    endtask

    initial begin
        #(20 * 100000);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        finish_run();
    end

    initial begin
        @(negedge clk);
        tick();
        load(cfg_a);
        commit();
        rst = 1'b0;
        // R4 R5 R7: vector sweep on combinational configuration A
        foreach (VEC[v]) begin
            nb_in = VEC[v][7:4];
            #2;
            check("R4/R7 vector", nb_out, VEC[v][3:0]);
            @(negedge clk);
        end
        // R2: cfg_bit wiggled with cfg_en low must not alter the shadow
        for (int i = 0; i < 80; i++) begin
            cfg_bit = i[0] ^ i[2];
            tick();
        end
        commit();
        nb_in = 4'b0101;
        #2;
        check("R2 ignored while disabled", nb_out, 4'h6);
        // R3: load B without commit, old function stays
        nb_in = 4'b0001;
        load(cfg_b);
        #2;
        check("R3 old function kept", nb_out, 4'hE);
        commit();
        rst = 1'b1;
        tick();
        check("R1 reset clears registers", nb_out, 4'h0);
        rst = 1'b0;
        nb_in = 4'b0101;
        tick();
        check("R6 registered edge1", nb_out, 4'hD);
        nb_in = 4'b0010;
        #2;
        check("R6 no comb change", nb_out, 4'hD);
        tick();
        check("R5 feedback edge2", nb_out, 4'h2);
        tick();
        check("R5 feedback toggle", nb_out, 4'hA);
        rst = 1'b1;
        tick();
        check("R1 reset mid-run", nb_out, 4'h0);
        rst = 1'b0;
        tick();
        check("R1 config retained", nb_out, 4'hA);
        // R9: combinational north read back by registered south
        load(cfg_c);
        commit();
        rst = 1'b1;
        tick();
        rst = 1'b0;
        nb_in = 4'b0001;
        #2;
        check("R6 comb immediate", nb_out, 4'h9);
        tick();
        check("R9 delay edge1", nb_out, 4'h9);
        nb_in = 4'b0000;
        #2;
        check("R9 comb drop", nb_out, 4'h8);
        tick();
        check("R9 readback edge2", nb_out, 4'hA);
        tick();
        check("R9 readback edge3", nb_out, 4'h8);
        finish_run();
    end

endmodule